// File: doc/BRIEF.md
# Debug Test Access Port with Five Selectable Scan Chains

This block is the serial debug entry point of a chip. It runs the standard sixteen-state test access port state machine on the test clock `tck`, steered by the mode-select input `tms`. A four-bit instruction register chooses which of five internal debug scan chains sits between the serial input `tdi` and the serial output `tdo`. A one-bit bypass register takes that place instead when no chain is chosen. The chains themselves live outside this block. Each chain gets its own capture, shift and update strobes, and all chains share one serial input, `chainTdi`. Each chain returns its serial output on `chainSo`.

All sampling and all output updates happen on the rising edge of `tck`. Each bit shifted out appears on `tdo` after the rising edge that shifted it, and `tdoOe` is high only in the cycles that follow a shift edge. The pad drives the pin only while `tdoOe` is high; at other times an external weak pull-down holds the pin. Two inputs force the controller asynchronously into Test-Logic-Reset: the active-low test reset pin, and a single pulse from the chip's power-on reset.

Top module: `jtag_multichain_tap`

## Requirements
- R1: While `trstN` is low, the controller is held in Test-Logic-Reset without waiting for a clock edge. `tdoOe` reads 0, every chain strobe reads 0, and the instruction register holds the bypass code 4'b1111.
- R2: A high level on `porRst` has the same asynchronous reset effect as R1. The chip pulses it once at power-on.
- R3: State changes follow the standard TAP graph on each rising `tck` edge. This includes the Pause-DR detour: Exit1-DR, Pause-DR, Exit2-DR, then back to Shift-DR.
- R4: Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state. Test-Logic-Reset forces the instruction register to 4'b1111.
- R5: Capture-IR loads 4'b0001 into the instruction shift register. Shift-IR moves `tdi` into bit 3 and sends bit 0 out first. Update-IR copies the shift register into the instruction register.
- R6: Instruction codes 0 to 4 select chain 0 to 4 respectively. The selected chain alone sees `chainCapture` in Capture-DR, `chainShift` in Shift-DR and `chainUpdate` in Update-DR. `chainTdi` always equals `tdi`.
- R7: Code 4'b1111 and every unassigned code (5 to 14) select the bypass register. No chain then sees any strobe.
- R8: The bypass register captures 0 in Capture-DR and loads `tdi` at each Shift-DR edge.
- R9: At a rising edge in Shift-IR or Shift-DR, `tdo` takes the outgoing bit and `tdoOe` goes to 1. The outgoing bit is the instruction shift register's bit 0, the bypass bit, or the selected chain's `chainSo`. At any other edge `tdoOe` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on the rising edge |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| trstN | input | 1 | Asynchronous active-low test reset |
| porRst | input | 1 | Asynchronous active-high power-on reset pulse |
| tdo | output | 1 | Serial test data out |
| tdoOe | output | 1 | Output enable for the `tdo` pad driver |
| chainTdi | output | 1 | Serial data in, shared by all chains |
| chainCapture | output | 5 | Per-chain capture strobe |
| chainShift | output | 5 | Per-chain shift enable |
| chainUpdate | output | 5 | Per-chain update strobe |
| chainSo | input | 5 | Per-chain serial data out |

## Verification
Data-register scans are run with each of the five chain codes. The behavioural chains in the bench capture distinct values, so a wrong selection or a wrong TDO mux leg changes the bits seen on `tdo`. The unassigned codes 5, 9 and 14 and the all-ones code are each run through a data scan, which separates bypass decode from chain decode and checks the captured 0 and the one-cycle delay. Other scans stop partway: some take the Pause-DR detour, some are cut by five `tms` ones, some by `trstN`, and some by a `porRst` pulse. These show whether state changes, the reset force of the instruction register and asynchronous reset all match the reference model on every clock.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  typedef enum logic [3:0] {
    TestReset, RunIdle,
    SelDr, CapDr, ShDr, Ex1Dr, PauseDr, Ex2Dr, UpdDr,
    SelIr, CapIr, ShIr, Ex1Ir, PauseIr, Ex2Ir, UpdIr
  } tapState_t;

  typedef struct packed {
    logic testReset;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
    logic updateDr;
  } tapStrobes_t;

endpackage

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import jtag_tap_pkg::*;
(
  input  logic        tck,
  input  logic        rstN,
  input  logic        tms,
  output tapStrobes_t strb
);

  tapState_t st, nxt;

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) st <= TestReset;
    else       st <= nxt;
  end

  always_comb begin
    nxt = st;
    case (st)
      TestReset: nxt = tms ? TestReset : RunIdle;
      RunIdle:   nxt = tms ? SelDr : RunIdle;
      SelDr:     nxt = tms ? SelIr : CapDr;
      CapDr:     nxt = tms ? Ex1Dr : ShDr;
      ShDr:      nxt = tms ? Ex1Dr : ShDr;
      Ex1Dr:     nxt = tms ? UpdDr : PauseDr;
      PauseDr:   nxt = tms ? Ex2Dr : PauseDr;
      Ex2Dr:     nxt = tms ? UpdDr : ShDr;
      UpdDr:     nxt = tms ? SelDr : RunIdle;
      SelIr:     nxt = tms ? TestReset : CapIr;
      CapIr:     nxt = tms ? Ex1Ir : ShIr;
      ShIr:      nxt = tms ? Ex1Ir : ShIr;
      Ex1Ir:     nxt = tms ? UpdIr : PauseIr;
      PauseIr:   nxt = tms ? Ex2Ir : PauseIr;
      Ex2Ir:     nxt = tms ? UpdIr : ShIr;
      UpdIr:     nxt = tms ? SelDr : RunIdle;
      default:   nxt = TestReset;
    endcase
  end

  always_comb begin
    strb.testReset = (st == TestReset);
    strb.captureIr = (st == CapIr);
    strb.shiftIr   = (st == ShIr);
    strb.updateIr  = (st == UpdIr);
    strb.captureDr = (st == CapDr);
    strb.shiftDr   = (st == ShDr);
    strb.updateDr  = (st == UpdDr);
  end

endmodule

// File: rtl/tap_datapath.sv
module tap_datapath
  import jtag_tap_pkg::*;
#(
  parameter int NUM_CHAINS = 5,
  parameter int IR_WIDTH   = 4,
  parameter logic [IR_WIDTH-1:0] IR_CAPTURE = 1
)(
  input  logic                  tck,
  input  logic                  rstN,
  input  logic                  tdi,
  input  tapStrobes_t           strb,
  input  logic [NUM_CHAINS-1:0] chainSo,
  output logic [NUM_CHAINS-1:0] chainSel,
  output logic                  bypassSel,
  output logic                  tdo,
  output logic                  tdoOe
);

  localparam logic [IR_WIDTH-1:0] IR_BYPASS = '1;

  logic [IR_WIDTH-1:0] irShift, irReg;
  logic                bypassBit;
  logic                drSo;

  // instruction shift register and instruction register (R4, R5)
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      irShift <= '0;
      irReg   <= IR_BYPASS;
    end else begin
      if (strb.captureIr)    irShift <= IR_CAPTURE;
      else if (strb.shiftIr) irShift <= {tdi, irShift[IR_WIDTH-1:1]};
      if (strb.testReset)     irReg <= IR_BYPASS;
      else if (strb.updateIr) irReg <= irShift;
    end
  end

  // instruction decode: one select line per chain (R6, R7)
  for (genvar i = 0; i < NUM_CHAINS; i++) begin : g_dec
    assign chainSel[i] = (irReg == IR_WIDTH'(i));
  end
  assign bypassSel = ~|chainSel;

  // one-bit bypass register (R8)
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)                               bypassBit <= 1'b0;
    else if (strb.captureDr && bypassSel)    bypassBit <= 1'b0;
    else if (strb.shiftDr && bypassSel)      bypassBit <= tdi;
  end

  assign drSo = bypassSel ? bypassBit : |(chainSo & chainSel);

  // TDO launched on the rising edge (R9)
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      tdo   <= 1'b0;
      tdoOe <= 1'b0;
    end else if (strb.shiftIr) begin
      tdo   <= irShift[0];
      tdoOe <= 1'b1;
    end else if (strb.shiftDr) begin
      tdo   <= drSo;
      tdoOe <= 1'b1;
    end else begin
      tdoOe <= 1'b0;
    end
  end

endmodule

// File: rtl/jtag_multichain_tap.sv
module jtag_multichain_tap
  import jtag_tap_pkg::*;
#(
  parameter int NUM_CHAINS = 5,
  parameter int IR_WIDTH   = 4
)(
  input  logic                  tck,
  input  logic                  tms,
  input  logic                  tdi,
  input  logic                  trstN,
  input  logic                  porRst,
  output logic                  tdo,
  output logic                  tdoOe,
  output logic                  chainTdi,
  output logic [NUM_CHAINS-1:0] chainCapture,
  output logic [NUM_CHAINS-1:0] chainShift,
  output logic [NUM_CHAINS-1:0] chainUpdate,
  input  logic [NUM_CHAINS-1:0] chainSo
);

  localparam logic [IR_WIDTH-1:0] IR_CAPTURE = IR_WIDTH'(1);

  logic                  rstN;
  tapStrobes_t           strb;
  logic [NUM_CHAINS-1:0] chainSel;
  logic                  bypassSel;

  // either reset source forces Test-Logic-Reset (R1, R2)
  assign rstN = trstN & ~porRst;

  tap_ctrl u_ctrl (
    .tck  (tck),
    .rstN (rstN),
    .tms  (tms),
    .strb (strb)
  );

  tap_datapath #(
    .NUM_CHAINS (NUM_CHAINS),
    .IR_WIDTH   (IR_WIDTH),
    .IR_CAPTURE (IR_CAPTURE)
  ) u_dp (
    .tck       (tck),
    .rstN      (rstN),
    .tdi       (tdi),
    .strb      (strb),
    .chainSo   (chainSo),
    .chainSel  (chainSel),
    .bypassSel (bypassSel),
    .tdo       (tdo),
    .tdoOe     (tdoOe)
  );

  assign chainTdi = tdi;

  for (genvar i = 0; i < NUM_CHAINS; i++) begin : g_chain
    assign chainCapture[i] = strb.captureDr & chainSel[i];
    assign chainShift[i]   = strb.shiftDr   & chainSel[i];
    assign chainUpdate[i]  = strb.updateDr  & chainSel[i];
  end

endmodule

// File: rtl/tap_checker.sv
module tap_checker
  import jtag_tap_pkg::*;
#(
  parameter int NUM_CHAINS = 5
)(
  input logic                  tck,
  input logic                  rstN,
  input logic                  tms,
  input tapStrobes_t           strb,
  input logic                  bypassSel,
  input logic [NUM_CHAINS-1:0] chainCapture,
  input logic [NUM_CHAINS-1:0] chainShift,
  input logic [NUM_CHAINS-1:0] chainUpdate,
  input logic                  tdoOe
);

  logic [2:0] onesCnt;

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)             onesCnt <= 3'd0;
    else if (!tms)         onesCnt <= 3'd0;
    else if (onesCnt < 5)  onesCnt <= onesCnt + 3'd1;
  end

  // R6: at most one chain strobed at a time
  a_r6_one_chain: assert property (@(posedge tck) disable iff (!rstN)
    $onehot0(chainCapture) && $onehot0(chainShift) && $onehot0(chainUpdate));

  // R7: bypass selection leaves all chains quiet
  a_r7_bypass_quiet: assert property (@(posedge tck) disable iff (!rstN)
    bypassSel |-> ((chainCapture | chainShift | chainUpdate) == '0));

  // R9: output enable follows a shift edge
  a_r9_oe_after_shift: assert property (@(posedge tck) disable iff (!rstN)
    (strb.shiftDr || strb.shiftIr) |=> tdoOe);

  a_r9_oe_off: assert property (@(posedge tck) disable iff (!rstN)
    !(strb.shiftDr || strb.shiftIr) |=> !tdoOe);

  // R4: five tms-high edges end in Test-Logic-Reset
  a_r4_five_ones: assert property (@(posedge tck) disable iff (!rstN)
    (onesCnt == 3'd5) |-> strb.testReset);

  // R3: Capture-DR with tms low goes to Shift-DR
  a_r3_cap_to_shift: assert property (@(posedge tck) disable iff (!rstN)
    (strb.captureDr && !tms) |=> strb.shiftDr);

endmodule

bind jtag_multichain_tap tap_checker #(.NUM_CHAINS(NUM_CHAINS)) u_chk (
  .tck          (tck),
  .rstN         (rstN),
  .tms          (tms),
  .strb         (strb),
  .bypassSel    (bypassSel),
  .chainCapture (chainCapture),
  .chainShift   (chainShift),
  .chainUpdate  (chainUpdate),
  .tdoOe        (tdoOe)
);

// File: tb/jtag_multichain_tap_tb.sv
`timescale 1ns/1ps
module jtag_multichain_tap_tb;

  localparam int NCH = 5;
  localparam int CLEN = 8;

  // bench-side state numbering
  localparam int S_TLR = 0, S_RTI = 1, S_SDR = 2, S_CDR = 3, S_SHDR = 4, S_E1DR = 5,
                 S_PDR = 6, S_E2DR = 7, S_UDR = 8, S_SIR = 9, S_CIR = 10, S_SHIR = 11,
                 S_E1IR = 12, S_PIR = 13, S_E2IR = 14, S_UIR = 15;

  logic tck = 1'b0;
  logic tms = 1'b1, tdi = 1'b0, trstN = 1'b0, porRst = 1'b0;
  logic tdo, tdoOe, chainTdi;
  logic [NCH-1:0] chainCapture, chainShift, chainUpdate;
  logic [NCH-1:0] chainSo = '0;

  always #2 tck = ~tck;

  jtag_multichain_tap u_dut (
    .tck(tck), .tms(tms), .tdi(tdi), .trstN(trstN), .porRst(porRst),
    .tdo(tdo), .tdoOe(tdoOe), .chainTdi(chainTdi),
    .chainCapture(chainCapture), .chainShift(chainShift),
    .chainUpdate(chainUpdate), .chainSo(chainSo)
  );

  int compared = 0, mismatched = 0;
  bit done = 0;
  string curReq = "R1";

  // reference model
  int mState;
  logic [3:0] mIr, mIrSh;
  logic mByp, mTdo, mOe;
  logic [CLEN-1:0] chainVal [NCH];

  function automatic int nextState(int s, logic m);
    case (s)
      S_TLR:  return m ? S_TLR  : S_RTI;
      S_RTI:  return m ? S_SDR  : S_RTI;
      S_SDR:  return m ? S_SIR  : S_CDR;
      S_CDR:  return m ? S_E1DR : S_SHDR;
      S_SHDR: return m ? S_E1DR : S_SHDR;
      S_E1DR: return m ? S_UDR  : S_PDR;
      S_PDR:  return m ? S_E2DR : S_PDR;
      S_E2DR: return m ? S_UDR  : S_SHDR;
      S_UDR:  return m ? S_SDR  : S_RTI;
      S_SIR:  return m ? S_TLR  : S_CIR;
      S_CIR:  return m ? S_E1IR : S_SHIR;
      S_SHIR: return m ? S_E1IR : S_SHIR;
      S_E1IR: return m ? S_UIR  : S_PIR;
      S_PIR:  return m ? S_E2IR : S_PIR;
      S_E2IR: return m ? S_UIR  : S_SHIR;
      default: return m ? S_SDR : S_RTI;
    endcase
  endfunction

  function automatic int selChain();
    return (mIr < NCH) ? int'(mIr) : -1;
  endfunction

  task automatic modelReset();
    mState = S_TLR; mIr = 4'hF; mIrSh = 4'h0; mByp = 1'b0; mOe = 1'b0; mTdo = 1'b0;
  endtask

  task automatic check(input bit ok, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", curReq, what, act, exp);
    end
  endtask

  task automatic compareOutputs();
    int s;
    logic [NCH-1:0] eCap, eSh, eUp;
    s = selChain();
    eCap = '0; eSh = '0; eUp = '0;
    if (s >= 0) begin
      if (mState == S_CDR)  eCap[s] = 1'b1;
      if (mState == S_SHDR) eSh[s]  = 1'b1;
      if (mState == S_UDR)  eUp[s]  = 1'b1;
    end
    check(chainCapture == eCap, "chainCapture", int'(chainCapture), int'(eCap));
    check(chainShift == eSh, "chainShift", int'(chainShift), int'(eSh));
    check(chainUpdate == eUp, "chainUpdate", int'(chainUpdate), int'(eUp));
    check(chainTdi == tdi, "chainTdi", int'(chainTdi), int'(tdi));
    check(tdoOe == mOe, "tdoOe", int'(tdoOe), int'(mOe));
    if (mOe) check(tdo == mTdo, "tdo", int'(tdo), int'(mTdo));
  endtask

  // one TCK cycle: drive at falling edge, compare, then model the rising edge
  task automatic step(input logic tmsV, input logic tdiV);
    int s;
    tms = tmsV; tdi = tdiV;
    #1;
    compareOutputs();
    @(posedge tck);
    #1;
    s = selChain();
    if (mState == S_SHIR) begin
      mTdo = mIrSh[0]; mOe = 1'b1;
    end else if (mState == S_SHDR) begin
      mTdo = (s >= 0) ? chainVal[s][0] : mByp; mOe = 1'b1;
    end else mOe = 1'b0;
    case (mState)
      S_TLR:  mIr = 4'hF;
      S_CIR:  mIrSh = 4'b0001;
      S_SHIR: mIrSh = {tdiV, mIrSh[3:1]};
      S_UIR:  mIr = mIrSh;
      S_CDR:  if (s >= 0) chainVal[s] = CLEN'(8'hC3 ^ (s * 8'h29)); else mByp = 1'b0;
      S_SHDR: if (s >= 0) chainVal[s] = {tdiV, chainVal[s][CLEN-1:1]}; else mByp = tdiV;
      default: ;
    endcase
    mState = nextState(mState, tmsV);
    for (int i = 0; i < NCH; i++) chainSo[i] = chainVal[i][0];
    @(negedge tck);
  endtask

  task automatic irScan(input logic [3:0] code);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) step(i == 3, code[i]);
    step(1, 0); step(0, 0);
  endtask

  task automatic drScan(input int nbits, input logic [31:0] pat);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < nbits; i++) step(i == nbits - 1, pat[i]);
    step(1, 0); step(0, 0);
  endtask

  task automatic drScanPaused(input logic [31:0] pat);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) step(i == 2, pat[i]);
    step(0, 0); step(0, 0); step(1, 0); step(0, 0);
    for (int i = 3; i < 6; i++) step(i == 5, pat[i]);
    step(1, 0); step(0, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) chainVal[i] = '0;
    modelReset();
    @(negedge tck); @(negedge tck);
    // R1: held in reset
    curReq = "R1";
    compareOutputs();
    trstN = 1'b1;
    step(1, 0); step(0, 0);
    // R8: bypass after reset, captured 0 then delayed tdi
    curReq = "R8";
    drScan(12, 32'h0000_0B5D);
    // R5 and R6: every chain code, capture values seen on tdo
    for (int c = 0; c < NCH; c++) begin
      curReq = "R5";
      irScan(4'(c));
      curReq = "R6";
      drScan(10 + c, 32'h0000_2D3 ^ (c * 32'h5A));
    end
    // R7: unassigned codes and all-ones give bypass
    curReq = "R7";
    irScan(4'd5);  drScan(6, 32'h2B);
    irScan(4'd9);  drScan(6, 32'h15);
    irScan(4'd14); drScan(6, 32'h33);
    irScan(4'd15); drScan(6, 32'h2A);
    // R3: Pause-DR detour on a chain
    curReq = "R3";
    irScan(4'd3);
    drScanPaused(32'h25);
    irScan(4'd1);
    drScanPaused(32'h1A);
    // R4: five tms ones from mid-shift, IR forced to bypass
    curReq = "R4";
    irScan(4'd2);
    step(1, 0); step(0, 0); step(0, 1); step(0, 0);
    for (int i = 0; i < 5; i++) step(1, 0);
    step(0, 0);
    drScan(5, 32'h13);
    // R1: asynchronous trstN in the middle of a chain shift
    curReq = "R1";
    irScan(4'd4);
    step(1, 0); step(0, 0); step(0, 1); step(0, 1);
    trstN = 1'b0; #1;
    modelReset();
    compareOutputs();
    @(negedge tck);
    trstN = 1'b1;
    step(0, 0);
    drScan(4, 32'h9);
    // R2: power-on pulse in the middle of an instruction shift
    curReq = "R2";
    irScan(4'd0);
    step(1, 0); step(1, 0); step(0, 0); step(0, 1); step(0, 0);
    porRst = 1'b1; #1;
    modelReset();
    compareOutputs();
    @(negedge tck);
    porRst = 1'b0;
    step(0, 0);
    drScan(5, 32'h16);
    // R9: back-to-back scans, enable drops between them
    curReq = "R9";
    irScan(4'd1);
    drScan(9, 32'h1C7);
    for (int i = 0; i < 5; i++) step(1, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule